// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block keeps calendar time as packed BCD counters for seconds, minutes, hours, weekday, day of month, month and two-digit year, and advances them on each pulse of a one-per-second tick input. Software never reads the counters directly. It reads a bank of shadow bytes that sit in the top eight locations of a 13-bit byte address space. The shadow bytes are all refreshed together once per second from the counters.

A control byte carries two halt flags. The freeze flag stops shadow refreshes so that software can read a consistent time while the counters keep running. The load flag also stops refreshes, so that software can write new time values into the shadow bytes. A write to the control byte that clears the load flag copies the seven time bytes into the counters in one step. A stop flag in the seconds byte holds the counters still.

The port is a plain synchronous byte interface. A write is taken on the clock edge where `wr_en` is high. Read data follows the address combinationally.

Top module: `bcd_rtc_regs`

## Requirements
- R1: Byte index 0 of the window 0x1FF8-0x1FFF is control. Indices 1 to 7 are, in order, seconds, minutes, hours, weekday, day of month, month and year. Any address outside the window reads 0x00, and a write to such an address changes nothing.
- R2: Bits with no defined meaning are stored as 0 and read as 0. The kept-bit masks are: control 0xC0 (bit 7 load, bit 6 freeze), seconds 0xFF (bit 7 stop), minutes 0x7F, hours 0x3F, weekday 0x47 (bit 6 frequency-test flag, bits 2:0 weekday), day of month 0x3F, month 0x1F, year 0xFF.
- R3: On each tick, seconds count 00-59 and minutes count 00-59 in BCD, each carrying into the next field on wrap. Hours count 00-23 and carry into the day fields on wrap.
- R4: On a day change, the weekday advances and wraps from 07 to 01.
- R5: The day of month wraps to 01 after the last day of the month. That last day is 31, except 30 for months 04, 06, 09 and 11, and for month 02 it is 29 when the year value is divisible by four and 28 otherwise.
- R6: The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R7: When neither halt flag is set, all seven time shadow bytes take the counter values together, on the clock edge after the tick edge.
- R8: While the freeze flag is set, the shadow bytes hold still and the counters keep counting. After the flag is cleared, the next refresh shows the current time.
- R9: A halt flag written in the same cycle as a pending refresh does not cancel that refresh.
- R10: While the load flag is set, software writes land in the shadow bytes and are not overwritten. A control write that clears the load flag loads all seven time bytes into the counters.
- R11: While the stop bit (seconds bit 7) in the counters is 1, ticks leave every counter unchanged. After the stop bit is cleared, counting resumes from the loaded values.
- R12: A write to a time byte while no halt flag is set is visible at once. It is replaced by the counter value at the next refresh.
- R13: After reset, control, seconds, minutes, hours and year read 0x00, and weekday, day of month and month read 0x01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Write strobe |
| addr | input | 13 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |

## Verification
Several checks run on every cycle. They cover the carry out of 59 seconds, the frozen counters while the stop bit is set, the unchanged shadow bank while a halt flag stays set, the exact copy on a commit, the refresh one cycle after a tick, and zero reads outside the window and in the unused control bits. Some behaviours can only be shown by the bench's scenarios. These are the calendar carries through month ends, leap years and the year wrap, the refresh that still happens when a halt arrives as it is due, and the overwrite of an unhalted write at the next refresh.

// File: rtl/bcd_rtc_regs.sv
module bcd_rtc_regs #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1hz,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  localparam logic [AW-4:0] WINDOW = '1;

  logic [7:0][7:0] sh;
  logic [7:1][7:0] cnt, nxt;
  logic            pend;
  logic            hit, commit, halt, leap;
  logic [2:0]      idx;
  logic [7:0]      mlast, s_inc;

  function automatic logic [7:0] bmask(input logic [2:0] i);
    case (i)
      3'd0: bmask = 8'hC0;
      3'd2: bmask = 8'h7F;
      3'd3: bmask = 8'h3F;
      3'd4: bmask = 8'h47;
      3'd5: bmask = 8'h3F;
      3'd6: bmask = 8'h1F;
      default: bmask = 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] binc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) binc = {v[7:4] + 4'd1, 4'd0};
    else                binc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  assign idx    = addr[2:0];
  assign hit    = (addr[AW-1:3] == WINDOW);
  assign halt   = sh[0][7] | sh[0][6];
  assign commit = wr_en && hit && (idx == 3'd0) && sh[0][7] && !wdata[7];
  assign rdata  = hit ? sh[idx] : 8'h00;

  assign leap  = cnt[7][4] ? (cnt[7][3:0] == 4'd2 || cnt[7][3:0] == 4'd6)
                           : (cnt[7][3:0] == 4'd0 || cnt[7][3:0] == 4'd4 || cnt[7][3:0] == 4'd8);
  assign mlast = (cnt[6] == 8'h02) ? (leap ? 8'h29 : 8'h28) :
                 (cnt[6] == 8'h04 || cnt[6] == 8'h06 || cnt[6] == 8'h09 || cnt[6] == 8'h11)
                   ? 8'h30 : 8'h31;
  assign s_inc = binc({1'b0, cnt[1][6:0]});

  always_comb begin
    nxt = cnt;
    if (cnt[1][6:0] >= 7'h59) begin
      nxt[1][6:0] = 7'h00;
      if (cnt[2] >= 8'h59) begin
        nxt[2] = 8'h00;
        if (cnt[3] >= 8'h23) begin
          nxt[3] = 8'h00;
          nxt[4][2:0] = (cnt[4][2:0] >= 3'd7) ? 3'd1 : cnt[4][2:0] + 3'd1;
          if (cnt[5] >= mlast) begin
            nxt[5] = 8'h01;
            if (cnt[6] >= 8'h12) begin
              nxt[6] = 8'h01;
              nxt[7] = (cnt[7] >= 8'h99) ? 8'h00 : binc(cnt[7]);
            end else begin
              nxt[6] = binc(cnt[6]);
            end
          end else begin
            nxt[5] = binc(cnt[5]);
          end
        end else begin
          nxt[3] = binc(cnt[3]);
        end
      end else begin
        nxt[2] = binc(cnt[2]);
      end
    end else begin
      nxt[1][6:0] = s_inc[6:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
      sh   <= {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00};
      pend <= 1'b0;
    end else begin
      pend <= tick_1hz;
      if (commit)                     cnt <= sh[7:1];
      else if (tick_1hz && !cnt[1][7]) cnt <= nxt;
      if (pend && !halt)              sh[7:1] <= cnt;
      if (wr_en && hit)               sh[idx] <= wdata & bmask(idx);
    end
  end

  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !commit && !cnt[1][7] && cnt[1][6:0] == 7'h59 && cnt[2] == 8'h10)
      |=> (cnt[1][6:0] == 7'h00 && cnt[2] == 8'h11));

  assert_stop_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && (cnt[1][7] || !tick_1hz)) |=> $stable(cnt));

  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && $past(halt) && !$past(wr_en)) |-> $stable(sh));

  assert_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (cnt == $past(sh[7:1])));

  assert_refresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !halt && !wr_en) |=> (sh[7:1] == $past(cnt)));

  assert_outside_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (rdata == 8'h00));

  assert_ctrl_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && idx == 3'd0) |-> (rdata[5:0] == 6'd0));

endmodule

// File: tb/tb_bcd_rtc_regs.sv
module tb_bcd_rtc_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [12:0] BASE = 13'h1FF8;

  logic clk = 1'b0, rst_n = 1'b0, tick_1hz = 1'b0, wr_en = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0, rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  bcd_rtc_regs dut (.clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
                    .addr(addr), .wdata(wdata), .rdata(rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] i, input logic [7:0] exp);
    addr = BASE + 13'(i); #1;
    chk(tag, rdata, exp);
  endtask

  task automatic tick1();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, dw, dt, mo, y);
    wr(BASE, 8'h80);
    wr(BASE + 13'd1, s);  wr(BASE + 13'd2, mi); wr(BASE + 13'd3, h);
    wr(BASE + 13'd4, dw); wr(BASE + 13'd5, dt); wr(BASE + 13'd6, mo);
    wr(BASE + 13'd7, y);
    wr(BASE, 8'h00);
  endtask

  task automatic t_reset();
    rd_chk("R13 ctrl", 0, 8'h00); rd_chk("R13 sec", 1, 8'h00);
    rd_chk("R13 min", 2, 8'h00);  rd_chk("R13 hour", 3, 8'h00);
    rd_chk("R13 wday", 4, 8'h01); rd_chk("R13 date", 5, 8'h01);
    rd_chk("R13 month", 6, 8'h01); rd_chk("R13 year", 7, 8'h00);
  endtask

  task automatic t_map();
    wr(13'h1FF7, 8'hFF);
    addr = 13'h1FF7; #1; chk("R1 below window", rdata, 8'h00);
    addr = 13'h0000; #1; chk("R1 addr zero", rdata, 8'h00);
    rd_chk("R1 ctrl untouched", 0, 8'h00);
  endtask

  task automatic t_masks();
    wr(BASE, 8'hFF);       rd_chk("R2 ctrl mask", 0, 8'hC0);
    wr(BASE + 13'd2, 8'hFF); rd_chk("R2 min mask", 2, 8'h7F);
    wr(BASE + 13'd3, 8'hFF); rd_chk("R2 hour mask", 3, 8'h3F);
    wr(BASE + 13'd4, 8'hFF); rd_chk("R2 wday mask", 4, 8'h47);
    wr(BASE + 13'd5, 8'hFF); rd_chk("R2 date mask", 5, 8'h3F);
    wr(BASE + 13'd6, 8'hFF); rd_chk("R2 month mask", 6, 8'h1F);
    tick1();
    rd_chk("R10 load holds write", 6, 8'h1F);
    wr(BASE, 8'h00);
  endtask

  task automatic t_refresh();
    set_time(8'h30, 8'h15, 8'h08, 8'h02, 8'h10, 8'h05, 8'h21);
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    rd_chk("R7 before refresh edge", 1, 8'h30);
    @(negedge clk);
    rd_chk("R7 after refresh edge", 1, 8'h31);
    rd_chk("R10 commit min", 2, 8'h15);
    rd_chk("R10 commit year", 7, 8'h21);
  endtask

  task automatic t_rollover();
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    tick1();
    rd_chk("R3 sec wrap", 1, 8'h00); rd_chk("R3 min wrap", 2, 8'h00);
    rd_chk("R3 hour wrap", 3, 8'h00); rd_chk("R4 wday 7 to 1", 4, 8'h01);
    rd_chk("R5 date wrap", 5, 8'h01); rd_chk("R6 month wrap", 6, 8'h01);
    rd_chk("R6 year wrap", 7, 8'h00);
    set_time(8'h59, 8'h12, 8'h10, 8'h03, 8'h01, 8'h01, 8'h05);
    tick1();
    rd_chk("R3 minute carry", 2, 8'h13); rd_chk("R3 hour kept", 3, 8'h10);
  endtask

  task automatic t_months();
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
    tick1();
    rd_chk("R5 feb 28 non leap", 5, 8'h01); rd_chk("R5 to march", 6, 8'h03);
    rd_chk("R4 wday advance", 4, 8'h04);
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
    tick1();
    rd_chk("R5 feb 29 leap", 5, 8'h29); rd_chk("R5 still feb", 6, 8'h02);
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
    tick1();
    rd_chk("R5 leap end", 5, 8'h01); rd_chk("R5 leap march", 6, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h00);
    tick1();
    rd_chk("R5 year 00 leap", 5, 8'h29);
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h24);
    tick1();
    rd_chk("R5 april 30", 5, 8'h01); rd_chk("R5 to may", 6, 8'h05);
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h01, 8'h24);
    tick1();
    rd_chk("R5 jan 31", 5, 8'h31); rd_chk("R5 jan kept", 6, 8'h01);
  endtask

  task automatic t_freeze();
    set_time(8'h00, 8'h00, 8'h10, 8'h01, 8'h01, 8'h01, 8'h20);
    wr(BASE, 8'h40);
    tick1(); tick1(); tick1();
    rd_chk("R8 frozen", 1, 8'h00);
    wr(BASE, 8'h00);
    rd_chk("R8 no commit on clear", 1, 8'h00);
    tick1();
    rd_chk("R8 counters ran", 1, 8'h04);
  endtask

  task automatic t_halt_race();
    set_time(8'h20, 8'h00, 8'h10, 8'h01, 8'h01, 8'h01, 8'h20);
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0; wr_en = 1'b1; addr = BASE; wdata = 8'h40;
    @(negedge clk); wr_en = 1'b0;
    rd_chk("R9 update completes", 1, 8'h21);
    tick1();
    rd_chk("R9 then frozen", 1, 8'h21);
    wr(BASE, 8'h00);
  endtask

  task automatic t_stop();
    set_time(8'h80, 8'h00, 8'h12, 8'h01, 8'h01, 8'h01, 8'h20);
    tick1(); tick1(); tick1();
    rd_chk("R11 stopped sec", 1, 8'h80);
    rd_chk("R11 stopped min", 2, 8'h00);
    wr(BASE, 8'h80); wr(BASE + 13'd1, 8'h00); wr(BASE, 8'h00);
    tick1();
    rd_chk("R11 restart", 1, 8'h01);
  endtask

  task automatic t_overwrite();
    set_time(8'h05, 8'h10, 8'h07, 8'h01, 8'h01, 8'h01, 8'h20);
    wr(BASE + 13'd2, 8'h45);
    rd_chk("R12 write visible", 2, 8'h45);
    tick1();
    rd_chk("R12 overwritten", 2, 8'h10);
    rd_chk("R12 sec live", 1, 8'h06);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_masks();
    t_refresh();
    t_rollover();
    t_months();
    t_freeze();
    t_halt_race();
    t_stop();
    t_overwrite();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule